// File: doc/BRIEF.md
# Branch Target and Link Unit

This block keeps the program counter of a word-aligned 32-bit RISC core and resolves direct branches. Each cycle the caller may present one 32-bit instruction word with a decode strobe, together with a taken flag it has already evaluated. The block recognises two branch encodings by their primary opcode. It pulls out the immediate of whichever form is present, appends two zero bits and sign-extends it. It then forms a target that is either relative to the branch's own address or absolute, and loads the next counter value.

A branch may also ask for its return address, which is the address of the following word, to be saved in a link register. That register can be read at any time. It can also be loaded from outside, so software moves into it can be modelled. When no instruction is decoded, a separate strobe steps the counter to the next word. When neither strobe is high, the counter holds.

Top module: `brtgt_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc_q` to the `RESET_VEC` parameter with its two low bits forced to zero, and sets `lnk_q` to zero.
- R2: The opcode is `instr_word[31:26]`. Value 18 selects the long form and value 16 selects the short form. With `dec_valid` high and any other opcode, `pc_q` advances by 4 and no branch link write takes place.
- R3: Long form: the field `instr_word[25:2]` gets `2'b00` appended and is sign-extended to 32 bits. The branch is always taken, whatever `cond_taken` is.
- R4: Short form: the field `instr_word[15:2]` gets `2'b00` appended and is sign-extended to 32 bits. `instr_word[25:16]` has no effect. The branch is taken only when `cond_taken` is 1; otherwise `pc_q` advances by 4.
- R5: When `instr_word[1]` is 0, the target is the extended immediate plus the current `pc_q`, modulo 2^32. When it is 1, the target is the extended immediate alone.
- R6: When `instr_word[0]` is 1 on a long or short branch with `dec_valid` high, `lnk_q` takes `pc_q + 4`, whether the branch is taken or not. When it is 0, the branch leaves `lnk_q` alone.
- R7: When `lnk_wr_en` is high, `lnk_q` takes `lnk_wr_data` on the next edge, unless a branch link write (R6) happens in the same cycle, in which case the branch wins.
- R8: When `dec_valid` is low, `seq_adv` high advances `pc_q` by 4, and `seq_adv` low holds it. When `dec_valid` is high, `seq_adv` has no effect.
- R9: Every value `pc_q` takes has its two low bits at zero.
- R10: `lnk_q` presents the link register contents continuously. It changes only through R1, R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction word being decoded |
| dec_valid | input | 1 | Decode strobe for `instr_word` |
| cond_taken | input | 1 | Taken flag for the short form, supplied by the caller |
| seq_adv | input | 1 | Step to the next word when nothing is decoded |
| lnk_wr_en | input | 1 | External link register write enable |
| lnk_wr_data | input | 32 | External link register write data |
| pc_q | output | 32 | Current program counter |
| lnk_q | output | 32 | Link register contents |

## Verification
The counter and the link register are the only state, and both drive outputs directly. A wrong update therefore shows on `pc_q` or `lnk_q` one edge after the cycle that caused it. Because every later relative target and return address is built from `pc_q`, a single bad step also shifts all following results. A cycle-by-cycle reference model finds it at the first differing edge. Sign extension, absolute selection and the choice between the long and short fields are separate from the adder, so the bench exercises negative displacements, wrap past 2^32, and the bits each form must ignore.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
   localparam int INSN_W = 32;
   localparam int OPC_W  = 6;

   typedef enum logic [1:0] {
      BR_NONE  = 2'd0,
      BR_LONG  = 2'd1,
      BR_SHORT = 2'd2
   } br_kind_e;

   typedef struct packed {
      br_kind_e kind;
      logic     absolute;
      logic     link;
   } br_ctl_t;
endpackage

// File: rtl/brtgt_decode.sv
module brtgt_decode
   import brtgt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LONG_W    = 24,
   parameter int SHORT_W   = 14,
   parameter int OPC_LONG  = 18,
   parameter int OPC_SHORT = 16
) (
   input  logic [INSN_W-1:0] insn,
   output br_ctl_t           ctl,
   output logic [ADDR_W-1:0] imm_ext
);
   localparam int LONG_PAD  = ADDR_W - LONG_W - 2;
   localparam int SHORT_PAD = ADDR_W - SHORT_W - 2;

   generate
      if (LONG_W + 2 > INSN_W - OPC_W) begin : g_bad_long
         $error("long field overlaps opcode");
      end
      if (SHORT_W > 14 || SHORT_W < 2) begin : g_bad_short
         $error("short field width out of range");
      end
      if (LONG_PAD < 1 || SHORT_PAD < 1) begin : g_bad_addr
         $error("address width too narrow for branch fields");
      end
      if (OPC_LONG == OPC_SHORT) begin : g_bad_opc
         $error("branch opcodes must differ");
      end
   endgenerate

   logic [OPC_W-1:0]   opc;
   logic [LONG_W-1:0]  long_fld;
   logic [SHORT_W-1:0] short_fld;
   logic [ADDR_W-1:0]  long_ext;
   logic [ADDR_W-1:0]  short_ext;
   logic [9:0]         short_unused;

   assign opc          = insn[INSN_W-1 -: OPC_W];
   assign long_fld     = insn[LONG_W+1:2];
   assign short_fld    = insn[SHORT_W+1:2];
   assign short_unused = insn[25:16];

   // sign extension built bit by bit so each pad bit copies the field sign
   generate
      for (genvar b = 0; b < ADDR_W; b++) begin : g_ext
         if (b < 2) begin : g_zero
            assign long_ext[b]  = 1'b0;
            assign short_ext[b] = 1'b0;
         end else begin : g_data
            assign long_ext[b]  = (b < LONG_W + 2)  ? long_fld[(b < LONG_W + 2) ? b - 2 : 0]
                                                    : long_fld[LONG_W-1];
            assign short_ext[b] = (b < SHORT_W + 2) ? short_fld[(b < SHORT_W + 2) ? b - 2 : 0]
                                                    : short_fld[SHORT_W-1];
         end
      end
   endgenerate

   always_comb begin
      ctl.absolute = insn[1];
      ctl.link     = insn[0];
      if (opc == OPC_W'(OPC_LONG)) begin
         ctl.kind = BR_LONG;
         imm_ext  = long_ext;
      end else if (opc == OPC_W'(OPC_SHORT)) begin
         ctl.kind = BR_SHORT;
         imm_ext  = short_ext;
      end else begin
         ctl.kind = BR_NONE;
         imm_ext  = '0;
      end
   end

   logic unused_ok;
   assign unused_ok = ^short_unused;
endmodule

// File: rtl/brtgt_target.sv
module brtgt_target #(
   parameter int ADDR_W    = 32,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] imm,
   input  logic              absolute,
   output logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] seq_pc
);
   localparam int HALF = ADDR_W / 2;
   localparam int UPR  = ADDR_W - HALF;

   generate
      if (ADDR_W < 8) begin : g_bad_w
         $error("address width too small");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] sum;

   assign base = absolute ? '0 : pc;

   generate
      if (SPLIT_ADD) begin : g_csel
         logic [HALF:0]  lo_sum;
         logic [UPR-1:0] hi_c0;
         logic [UPR-1:0] hi_c1;
         assign lo_sum = {1'b0, base[HALF-1:0]} + {1'b0, imm[HALF-1:0]};
         assign hi_c0  = base[ADDR_W-1:HALF] + imm[ADDR_W-1:HALF];
         assign hi_c1  = base[ADDR_W-1:HALF] + imm[ADDR_W-1:HALF] + UPR'(1);
         assign sum    = {lo_sum[HALF] ? hi_c1 : hi_c0, lo_sum[HALF-1:0]};
      end else begin : g_plain
         assign sum = base + imm;
      end
   endgenerate

   assign target = {sum[ADDR_W-1:2], 2'b00};
   assign seq_pc = {pc[ADDR_W-1:2] + (ADDR_W-2)'(1), 2'b00};
endmodule

// File: rtl/brtgt_pc_reg.sv
module brtgt_pc_reg #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dec_valid,
   input  logic              seq_adv,
   input  logic              take,
   input  logic [ADDR_W-1:0] target,
   input  logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] pc_q
);
   localparam logic [ADDR_W-1:0] RV_ALIGN = {RESET_VEC[ADDR_W-1:2], 2'b00};

   logic [ADDR_W-1:0] pc_nxt;

   always_comb begin
      if (dec_valid)    pc_nxt = take ? target : seq_pc;
      else if (seq_adv) pc_nxt = seq_pc;
      else              pc_nxt = pc_q;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RV_ALIGN;
      else     pc_q <= pc_nxt;
   end
endmodule

// File: rtl/brtgt_link_reg.sv
module brtgt_link_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              br_link,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic              ext_en,
   input  logic [ADDR_W-1:0] ext_data,
   output logic [ADDR_W-1:0] lnk_q
);
   always_ff @(posedge clk) begin
      if (rst)          lnk_q <= '0;
      else if (br_link) lnk_q <= ret_addr;
      else if (ext_en)  lnk_q <= ext_data;
   end
endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
   import brtgt_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          LONG_W    = 24,
   parameter int          SHORT_W   = 14,
   parameter int          OPC_LONG  = 18,
   parameter int          OPC_SHORT = 16,
   parameter bit          SPLIT_ADD = 1'b0,
   parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [31:0] instr_word,
   input  logic        dec_valid,
   input  logic        cond_taken,
   input  logic        seq_adv,
   input  logic        lnk_wr_en,
   input  logic [31:0] lnk_wr_data,
   output logic [31:0] pc_q,
   output logic [31:0] lnk_q
);
   generate
      if (ADDR_W != 32) begin : g_bad_aw
         $error("port width fixed at 32 address bits");
      end
   endgenerate

   br_ctl_t           ctl;
   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] seq_pc;
   logic              is_branch;
   logic              take;
   logic              br_link;

   brtgt_decode #(
      .ADDR_W(ADDR_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W),
      .OPC_LONG(OPC_LONG), .OPC_SHORT(OPC_SHORT)
   ) u_dec (
      .insn    (instr_word),
      .ctl     (ctl),
      .imm_ext (imm_ext)
   );

   brtgt_target #(.ADDR_W(ADDR_W), .SPLIT_ADD(SPLIT_ADD)) u_tgt (
      .pc       (pc_q),
      .imm      (imm_ext),
      .absolute (ctl.absolute),
      .target   (target),
      .seq_pc   (seq_pc)
   );

   always_comb begin
      is_branch = (ctl.kind == BR_LONG) || (ctl.kind == BR_SHORT);
      take      = (ctl.kind == BR_LONG) || ((ctl.kind == BR_SHORT) && cond_taken);
      br_link   = dec_valid && is_branch && ctl.link;
   end

   brtgt_pc_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
      .clk       (clk),
      .rst       (rst),
      .dec_valid (dec_valid),
      .seq_adv   (seq_adv),
      .take      (take),
      .target    (target),
      .seq_pc    (seq_pc),
      .pc_q      (pc_q)
   );

   brtgt_link_reg #(.ADDR_W(ADDR_W)) u_lnk (
      .clk      (clk),
      .rst      (rst),
      .br_link  (br_link),
      .ret_addr (seq_pc),
      .ext_en   (lnk_wr_en),
      .ext_data (lnk_wr_data),
      .lnk_q    (lnk_q)
   );
endmodule

// File: rtl/brtgt_unit_chk.sv
module brtgt_unit_chk #(
   parameter int          LONG_W    = 24,
   parameter int          OPC_LONG  = 18,
   parameter int          OPC_SHORT = 16,
   parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
   input logic        clk,
   input logic        rst,
   input logic [31:0] instr_word,
   input logic        dec_valid,
   input logic        cond_taken,
   input logic        seq_adv,
   input logic        lnk_wr_en,
   input logic [31:0] lnk_wr_data,
   input logic [31:0] pc_q,
   input logic [31:0] lnk_q
);
   logic [5:0] opc;
   logic       is_long;
   logic       is_short;
   logic       brl;
   assign opc      = instr_word[31:26];
   assign is_long  = opc == 6'(OPC_LONG);
   assign is_short = opc == 6'(OPC_SHORT);
   assign brl      = dec_valid && (is_long || is_short) && instr_word[0];

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (pc_q == {RESET_VEC[31:2], 2'b00} && lnk_q == 32'd0));

   a_r9_pc_aligned: assert property (@(posedge clk) disable iff (rst)
      pc_q[1:0] == 2'b00);

   a_r2_other_opcode_steps: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && !is_long && !is_short) |=> pc_q == $past(pc_q) + 32'd4);

   a_r3_long_absolute: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && is_long && instr_word[1]) |=>
      pc_q == $past({{(32-LONG_W-2){instr_word[LONG_W+1]}}, instr_word[LONG_W+1:2], 2'b00}));

   a_r4_short_not_taken: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && is_short && !cond_taken) |=> pc_q == $past(pc_q) + 32'd4);

   a_r6_link_return: assert property (@(posedge clk) disable iff (rst)
      brl |=> lnk_q == $past(pc_q) + 32'd4);

   a_r7_ext_link_write: assert property (@(posedge clk) disable iff (rst)
      (lnk_wr_en && !brl) |=> lnk_q == $past(lnk_wr_data));

   a_r10_link_holds: assert property (@(posedge clk) disable iff (rst)
      (!lnk_wr_en && !brl) |=> $stable(lnk_q));

   a_r8_pc_holds: assert property (@(posedge clk) disable iff (rst)
      (!dec_valid && !seq_adv) |=> $stable(pc_q));
endmodule

bind brtgt_unit brtgt_unit_chk #(
   .LONG_W(LONG_W), .OPC_LONG(OPC_LONG), .OPC_SHORT(OPC_SHORT), .RESET_VEC(RESET_VEC)
) u_chk (
   .clk(clk), .rst(rst), .instr_word(instr_word), .dec_valid(dec_valid),
   .cond_taken(cond_taken), .seq_adv(seq_adv), .lnk_wr_en(lnk_wr_en),
   .lnk_wr_data(lnk_wr_data), .pc_q(pc_q), .lnk_q(lnk_q)
);

// File: tb/brtgt_unit_tb.sv
module brtgt_unit_tb_top;
   localparam int          CLK_P  = 10;
   localparam logic [31:0] RV_IN  = 32'h0000_0102;
   localparam logic [31:0] RV_EXP = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] instr_word;
   logic        dec_valid, cond_taken, seq_adv, lnk_wr_en;
   logic [31:0] lnk_wr_data;
   logic [31:0] pc_q, lnk_q;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_pc, m_lnk;

   always #(CLK_P/2) clk = ~clk;

   brtgt_unit #(.RESET_VEC(RV_IN)) dut_i (
      .clk(clk), .rst(rst), .instr_word(instr_word), .dec_valid(dec_valid),
      .cond_taken(cond_taken), .seq_adv(seq_adv), .lnk_wr_en(lnk_wr_en),
      .lnk_wr_data(lnk_wr_data), .pc_q(pc_q), .lnk_q(lnk_q)
   );

   // R3/R4 field extraction, R5 base selection
   function automatic logic [31:0] ref_target(input logic [31:0] pc, input logic [31:0] iw);
      logic [31:0] imm;
      if (iw[31:26] == 6'd18) imm = {{6{iw[25]}}, iw[25:2], 2'b00};
      else                    imm = {{16{iw[15]}}, iw[15:2], 2'b00};
      return iw[1] ? imm : pc + imm;
   endfunction

   function automatic logic [31:0] mk_insn(input int opc, input logic [23:0] fld, input logic aa, input logic lk);
      return {6'(opc), fld, aa, lk};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // called at a negedge; drives, clocks, updates model, checks at next negedge
   task automatic step(input logic r, input logic [31:0] iw, input logic dv, input logic ct,
                       input logic sa, input logic we, input logic [31:0] wd);
      logic is_l, is_s, tk;
      string tag;
      rst = r; instr_word = iw; dec_valid = dv; cond_taken = ct;
      seq_adv = sa; lnk_wr_en = we; lnk_wr_data = wd;
      @(posedge clk);
      is_l = iw[31:26] == 6'd18;
      is_s = iw[31:26] == 6'd16;
      tk   = is_l || (is_s && ct);
      if (r) begin
         m_pc = RV_EXP; m_lnk = '0; tag = "R1";
      end else if (dv) begin
         if ((is_l || is_s) && iw[0]) m_lnk = m_pc + 32'd4;
         else if (we)                 m_lnk = wd;
         if (tk) m_pc = ref_target(m_pc, iw);
         else    m_pc = m_pc + 32'd4;
         tag = is_l ? (iw[1] ? "R3/R5 abs" : "R3/R5 rel") :
               is_s ? (ct ? "R4/R5 taken" : "R4 not taken") : "R2 other";
         if ((is_l || is_s) && iw[0]) tag = {tag, " R6"};
      end else begin
         if (we) m_lnk = wd;
         if (sa) m_pc = m_pc + 32'd4;
         tag = sa ? "R8 seq" : "R8 hold";
      end
      @(negedge clk);
      check({tag, " pc"}, pc_q, m_pc);
      check({tag, " R10 lnk"}, lnk_q, m_lnk);
      if (pc_q[1:0] != 2'b00) check("R9 align", {30'd0, pc_q[1:0]}, 32'd0);
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      rst = 1'b1; instr_word = '0; dec_valid = 0; cond_taken = 0;
      seq_adv = 0; lnk_wr_en = 0; lnk_wr_data = '0;
      m_pc = '0; m_lnk = '0;
      @(negedge clk);
      step(1, 0, 0, 0, 0, 0, 0);                      // R1 reset with masked vector
      check("R1 reset pc", pc_q, 32'h0000_0100);
      check("R1 reset lnk", lnk_q, 32'd0);
      // R8 sequential, hold, and dec_valid overriding seq_adv
      step(0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, mk_insn(18, 24'h000010, 0, 0), 1, 0, 1, 0, 0);
      // R7 external write, then R6 wins over R7 in the same cycle
      step(0, 0, 0, 0, 0, 1, 32'hDEAD_BEE3);
      step(0, mk_insn(16, 24'hFFFFF8, 0, 1), 1, 0, 0, 1, 32'h1234_5678);
      // R4 upper field bits ignored; negative taken displacement
      step(0, mk_insn(16, 24'h3FFFF8, 0, 0), 1, 1, 0, 0, 0);
      // R3 long form taken with cond_taken low, negative wrap below zero
      step(0, mk_insn(18, 24'h800000, 0, 1), 1, 0, 0, 0, 0);
      // R5 absolute short form, negative sign-extends to high addresses
      step(0, mk_insn(16, 24'h002000, 1, 0), 1, 1, 0, 0, 0);
      // R5 absolute long form, largest positive
      step(0, mk_insn(18, 24'h7FFFFF, 1, 1), 1, 0, 0, 0, 0);
      // R2 non-branch opcode with link bit set: no link write
      step(0, mk_insn(17, 24'hFFFFFF, 1, 1), 1, 1, 0, 0, 0);
      for (int i = 0; i < 1500; i++) begin
         int sel;
         int opc;
         logic [31:0] lo;
         sel = int'($urandom % 4);
         opc = (sel < 2) ? 18 : (sel == 2) ? 16 : int'($urandom % 64);
         lo  = $urandom;
         step(($urandom % 200) == 0, {6'(opc), lo[25:0]}, ($urandom % 5) != 0,
              lo[31], lo[30], ($urandom % 4) == 0, $urandom);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule